// File: doc/BRIEF.md
# Burst Envelope Shaper with Mode Override

This block sits between a baseband modulator and a pair of 10-bit DAC registers. It takes the I and Q sample words and multiplies both by a burst amplitude envelope. At the start of a burst the envelope rises linearly to full scale over three symbol periods. At the end of a burst it falls linearly to zero over three symbol periods. Outside a burst the outputs stay at zero.

Two mode pins pick what reaches the DAC registers. In normal operation the enveloped modulator words pass through. In direct access the modulator and the envelope are bypassed and external words are loaded as they are. Frequency test keeps the envelope but replaces the data with I at zero and Q at positive full scale. The fourth encoding is reserved and drives zeros. Outputs change only on a sample strobe, one clock after it.

Top module: `burst_env_ramp`

## Requirements
- R1: While `rst_n` is low, and after it, until the first sample strobe, both outputs are zero and the envelope is idle at gain step zero.
- R2: The outputs are registered. They take a new value only in the clock after a cycle with `sample_valid` high. Otherwise they hold their value.
- R3: `burst_start` in the idle state begins a ramp-up from step 0. With RAMP = 3*SPS and STEP = (4096 + RAMP/2)/RAMP in integer division, the sample strobes of the ramp-up use gains 0, STEP, 2*STEP, ... up to (RAMP-1)*STEP, one step per strobe. Every strobe after that uses the full gain of 4096.
- R4: `burst_end` at full gain begins a ramp-down. Its strobes use gains 4096, (RAMP-1)*STEP, ... down to STEP, one step per strobe. Every strobe after that, including the whole fourth tail symbol, gives zero in normal mode.
- R5: In normal mode, mode1=0 and mode2=0, each output is the two's-complement value (s*gain + 2048) arithmetically shifted right by 12 and then saturated to [-512, 511]. Here s is the matching 10-bit signed modulator word.
- R6: With mode1=1 and mode2=0, the outputs are loaded directly from `dir_i` and `dir_q` on every strobe. The envelope has no effect on them.
- R7: With mode1=0 and mode2=1, I is zero and Q is the R5 scaling of 511 by the current envelope gain. The modulator words have no effect.
- R8: With mode1=1 and mode2=1, both outputs are zero on every strobe.
- R9: In normal and frequency-test modes, strobes before any `burst_start` give zero outputs.
- R10: A `burst_end` during ramp-up starts the ramp-down from the current step. A `burst_start` during ramp-down resumes the ramp-up from the current step. A `burst_start` at full gain is ignored. An event in the same cycle as a strobe takes priority: the step does not advance on that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Sample strobe; loads outputs and advances the envelope |
| burst_start | input | 1 | Begin or resume ramp-up |
| burst_end | input | 1 | Begin ramp-down |
| mode1 | input | 1 | Mode select, low bit |
| mode2 | input | 1 | Mode select, high bit |
| mod_i | input | 10 | Modulator I word, signed |
| mod_q | input | 10 | Modulator Q word, signed |
| dir_i | input | 10 | Direct-access I word, signed |
| dir_q | input | 10 | Direct-access Q word, signed |
| out_i | output | 10 | I DAC register value, signed |
| out_q | output | 10 | Q DAC register value, signed |

## Verification
The bench builds the block with SPS=2, which gives RAMP=6 and STEP=683. A complete burst, both ramps and the zero tail symbol then take only a few dozen strobes, and every gain step can be compared exactly. The short window also makes the reversals mid-ramp easy to reach at a known step. These are a `burst_end` after two ramp-up strobes and a `burst_start` partway down the ramp.

// File: rtl/burst_env_ramp.sv
module burst_env_ramp #(
  parameter int SPS = 8,
  parameter int DW  = 10,
  parameter int GF  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic                 burst_start,
  input  logic                 burst_end,
  input  logic                 mode1,
  input  logic                 mode2,
  input  logic signed [DW-1:0] mod_i,
  input  logic signed [DW-1:0] mod_q,
  input  logic signed [DW-1:0] dir_i,
  input  logic signed [DW-1:0] dir_q,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int RAMP = 3 * SPS;
  localparam int CW   = $clog2(RAMP + 1);
  localparam int ONE  = 1 << GF;
  localparam int STEP = (ONE + RAMP / 2) / RAMP;
  localparam int PW   = DW + GF + 3;
  localparam int MAXI = (1 << (DW - 1)) - 1;
  localparam int MINI = -(1 << (DW - 1));

  typedef enum logic [1:0] {S_IDLE, S_UP, S_FULL, S_DOWN} st_t;

  st_t           st;
  logic [CW-1:0] g;
  logic [GF:0]   gain;

  assign gain = (32'(g) == RAMP) ? (GF+1)'(ONE) : (GF+1)'(32'(g) * STEP);

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] s,
                                                 input logic [GF:0] gn);
    logic signed [PW-1:0] p;
    p = (PW'(s) * PW'($signed({1'b0, gn})) + PW'(ONE / 2)) >>> GF;
    if (p > PW'(MAXI))      scale = DW'(MAXI);
    else if (p < PW'(MINI)) scale = DW'(MINI);
    else                    scale = p[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      g     <= '0;
      out_i <= '0;
      out_q <= '0;
    end else begin
      if (burst_start || burst_end) begin
        case (st)
          S_IDLE: if (burst_start) begin st <= S_UP; g <= '0; end
          S_UP:   if (burst_end) st <= S_DOWN;
          S_FULL: if (burst_end) st <= S_DOWN;
          S_DOWN: if (burst_start) st <= S_UP;
        endcase
      end else if (sample_valid) begin
        case (st)
          S_UP: begin
            if (32'(g) >= RAMP - 1) begin g <= CW'(RAMP); st <= S_FULL; end
            else g <= g + 1'b1;
          end
          S_DOWN: begin
            if (g <= 1) begin g <= '0; st <= S_IDLE; end
            else g <= g - 1'b1;
          end
          default: ;
        endcase
      end
      if (sample_valid) begin
        case ({mode2, mode1})
          2'b00: begin out_i <= scale(mod_i, gain); out_q <= scale(mod_q, gain); end
          2'b01: begin out_i <= dir_i; out_q <= dir_q; end
          2'b10: begin out_i <= '0; out_q <= scale(DW'(MAXI), gain); end
          default: begin out_i <= '0; out_q <= '0; end
        endcase
      end
    end
  end

  assert_gain_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(g) <= RAMP);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(out_i) && $stable(out_q));

  assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && mode1 && !mode2 |=> out_i == $past(dir_i) && out_q == $past(dir_q));

  assert_ftest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !mode1 && mode2 |=> out_i == 0 && out_q >= 0);

  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && mode1 && mode2 |=> out_i == 0 && out_q == 0);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && st == S_IDLE && !mode1 |=> out_i == 0 && out_q == 0);
endmodule

// File: tb/tb_burst_env_ramp.sv
module tb_burst_env_ramp;
  localparam int SPS  = 2;
  localparam int RAMP = 3 * SPS;
  localparam int STEP = (4096 + RAMP / 2) / RAMP;

  logic clk = 0, rst_n = 0, sample_valid = 0, burst_start = 0, burst_end = 0;
  logic mode1 = 0, mode2 = 0;
  logic signed [9:0] mod_i = 0, mod_q = 0, dir_i = 0, dir_q = 0;
  logic signed [9:0] out_i, out_q;

  burst_env_ramp #(.SPS(SPS)) dut (.*);

  always #2.5 clk = ~clk;

  localparam logic signed [9:0] TI [8] = '{10'sd511, -10'sd512, 10'sd100, -10'sd77,
                                           10'sd3, 10'sd255, -10'sd1, 10'sd0};
  localparam logic signed [9:0] TQ [8] = '{-10'sd300, 10'sd511, -10'sd512, 10'sd42,
                                           10'sd1, -10'sd256, 10'sd400, -10'sd5};

  int total = 0, bad = 0;
  int mg = 0, mst = 0;

  function automatic int gain_of(int g);
    return (g == RAMP) ? 4096 : g * STEP;
  endfunction

  function automatic int scl(int s, int gn);
    int p;
    p = (s * gn + 2048) >>> 12;
    if (p > 511) p = 511;
    if (p < -512) p = -512;
    return p;
  endfunction

  task automatic chk(string tag, int gi, int ei, int gq, int eq);
    total++;
    if (gi != ei || gq != eq) begin
      bad++;
      $display("FAIL %s: got i=%0d q=%0d expected i=%0d q=%0d", tag, gi, gq, ei, eq);
    end
  endtask

  task automatic ev(bit st_ev);
    @(negedge clk);
    if (st_ev) burst_start = 1; else burst_end = 1;
    @(negedge clk);
    burst_start = 0; burst_end = 0;
    if (st_ev) begin
      if (mst == 0) begin mst = 1; mg = 0; end
      else if (mst == 3) mst = 1;
    end else if (mst == 1 || mst == 2) mst = 3;
  endtask

  task automatic smp(string tag, logic [1:0] m, int mi, int mq, int di, int dq);
    int ei, eq, gn;
    gn = gain_of(mg);
    case (m)
      2'b00: begin ei = scl(mi, gn); eq = scl(mq, gn); end
      2'b01: begin ei = di; eq = dq; end
      2'b10: begin ei = 0; eq = scl(511, gn); end
      default: begin ei = 0; eq = 0; end
    endcase
    @(negedge clk);
    {mode2, mode1} = m;
    mod_i = 10'(mi); mod_q = 10'(mq); dir_i = 10'(di); dir_q = 10'(dq);
    sample_valid = 1;
    @(negedge clk);
    sample_valid = 0;
    chk(tag, out_i, ei, out_q, eq);
    if (mst == 1) begin
      if (mg >= RAMP - 1) begin mg = RAMP; mst = 2; end else mg++;
    end else if (mst == 3) begin
      if (mg <= 1) begin mg = 0; mst = 0; end else mg--;
    end
  endtask

  initial begin
    #(5 * 100000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", out_i, 0, out_q, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", out_i, 0, out_q, 0);

    for (int k = 0; k < 3; k++) smp("R9 pre-burst", 2'b00, TI[k], TQ[k], 0, 0);
    smp("R9 pre-burst ftest", 2'b10, 0, 0, 0, 0);

    // R3 ramp-up, R5 full gain, R4 ramp-down and tail, table-driven
    ev(1);
    for (int k = 0; k < RAMP + 4; k++)
      smp(k < RAMP ? "R3 ramp-up" : "R5 full", 2'b00, TI[k % 8], TQ[k % 8], 0, 0);
    ev(0);
    for (int k = 0; k < RAMP + SPS; k++)
      smp(k < RAMP ? "R4 ramp-down" : "R4 tail zero", 2'b00, TI[k % 8], TQ[k % 8], 0, 0);

    // R2 hold without strobe
    smp("R2 load", 2'b01, 0, 0, 123, -45);
    @(negedge clk); dir_i = 10'sd7; dir_q = 10'sd9; mode1 = 0;
    @(negedge clk); @(negedge clk);
    chk("R2 hold", out_i, 123, out_q, -45);

    // R6 direct access ignores envelope, idle and mid-burst
    smp("R6 direct idle", 2'b01, 300, 300, -512, 511);
    ev(1);
    smp("R6 direct ramp", 2'b01, 300, 300, 17, -99);
    smp("R5 ramp step", 2'b00, 511, -512, 0, 0);

    // R7 frequency test with envelope
    for (int k = 0; k < RAMP + 2; k++) smp("R7 ftest", 2'b10, TI[k % 8], TQ[k % 8], 0, 0);
    // R10 start at full ignored
    ev(1);
    smp("R10 start at full", 2'b00, 200, -200, 0, 0);
    // R8 reserved
    smp("R8 reserved", 2'b11, 200, -200, 50, 50);
    ev(0);
    smp("R7 ftest down", 2'b10, 0, 0, 0, 0);
    smp("R7 ftest down", 2'b10, 0, 0, 0, 0);
    // R10 resume up mid-ramp-down
    ev(1);
    for (int k = 0; k < 4; k++) smp("R10 resume up", 2'b00, 400, -400, 0, 0);
    // R10 end during ramp-up
    ev(0);
    for (int k = 0; k < RAMP + 1; k++) smp("R4 down to zero", 2'b00, 400, -400, 0, 0);
    ev(1);
    smp("R10 up", 2'b00, 400, 400, 0, 0);
    smp("R10 up", 2'b00, 400, 400, 0, 0);
    ev(0);
    for (int k = 0; k < 4; k++) smp("R10 end mid-up", 2'b00, 400, 400, 0, 0);
    smp("R9 idle again", 2'b10, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule